// File: doc/BRIEF.md
# Configuration Port Controller with Banked GPIO

This block is a two-address configuration port for a simple I/O bus. One address holds an index register and the neighbouring address is a data window. Software writes the number of a configuration register to the index address and then reads or writes that register through the data address. The space stays hidden until a two-write entry key is written to the index address, and it is hidden again when an exit key is written there. While it is open, software can reach a logical-device selector, fixed identification bytes and, when the GPIO device is selected, a set of GPIO banks.

Each GPIO bank has four registers: pin direction, output level, synchronized input state and output drive style. Together they drive an output level and an output enable for each pad of the bank. Banks are placed downward from the top of the index space, and a bank may implement fewer than eight pins.

The lock logic is a three-state machine:
- `ST_LOCKED` is the reset state. An entry-key index write moves it to `ST_KEY_ONE`; any other index write leaves it in `ST_LOCKED`.
- `ST_KEY_ONE` moves to `ST_OPEN` on a second consecutive entry-key index write. Any other index write sends it back to `ST_LOCKED`.
- `ST_OPEN` returns to `ST_LOCKED` on an exit-key index write.

Data-port accesses never change the lock state.

Top module: `cfgport_ctrl`

## Requirements
- R1: With io_addr=0 the bus reaches the index register and with io_addr=1 it reaches the register that the index selects. While open, an index read returns the last index written. io_rdata is 0x00 whenever io_rd is low.
- R2: From the locked state, the space opens only after two consecutive index writes of 0x87. Any other index write between them restarts the key sequence.
- R3: An index write of 0xAA while open locks the space. Pad outputs keep their values when the space locks.
- R4: While the space is not open, data-port writes are ignored, and reads of either port return 0xFF.
- R5: Index 0x07 is a read/write logical-device register. GPIO bank registers respond only while it holds 0x06. Otherwise bank indices read 0x00 and writes to them are ignored.
- R6: Index 0x20 reads the device ID high byte, 0x21 the low byte and 0x22 the revision. Index 0x23 reads 0x19 and 0x24 reads 0x34. These registers are read-only.
- R7: Bank k occupies indices 0xF0-0x10*k to +3: direction at +0, output level at +1, input state at +2 (writes ignored) and drive style at +3. Bit i of each register belongs to pin i.
- R8: Pin i of bank k drives pad bit 8*k+i. Direction 0 gives oe=0. Direction 1 with drive style 1 (push-pull) gives oe=1 and out equal to the level bit. Direction 1 with drive style 0 (open-drain) gives out=0 and oe equal to the inverse of the level bit.
- R9: The input-state register shows a pad level two rising edges after the pad changes, and not after only one edge.
- R10: Bits of a bank at or above its pin count read as 0, ignore writes, and hold both pad out and pad oe at 0.
- R11: Reset locks the space, clears the logical-device register, and makes every pin an open-drain input with output level 0, so that all of pad_oe and pad_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| pad_in | input | NUM_BANKS*8 | Asynchronous pad levels |
| pad_out | output | NUM_BANKS*8 | Pad output levels |
| pad_oe | output | NUM_BANKS*8 | Pad output enables |

## Verification
The bench breaks the entry key with a foreign index write between the two 0x87 writes. A design that only counts key writes would then open one write early. Data writes made while the space is locked are later read back after unlocking, so a leaky write gate shows up as a changed logical-device value. Readback of a five-pin bank and of the opposite drive styles catches a wrong bit mask or an inverted open-drain enable. The input register is read one edge and then two edges after the pad changes, which exposes a missing or extra synchronizer stage.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED  = 2'd0,
        ST_KEY_ONE = 2'd1,
        ST_OPEN    = 2'd2
    } lock_state_e;

    localparam logic [7:0] KEY_ENTER   = 8'h87;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] IDX_LDEV    = 8'h07;
    localparam logic [7:0] IDX_DID_HI  = 8'h20;
    localparam logic [7:0] IDX_DID_LO  = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_MID_HI  = 8'h23;
    localparam logic [7:0] IDX_MID_LO  = 8'h24;
    localparam logic [7:0] LDEV_GPIO   = 8'h06;
    localparam logic [7:0] BANK_TOP    = 8'hF0;
    localparam int         BANK_STRIDE = 16;
    localparam logic [7:0] LOCKED_READ = 8'hFF;

endpackage

// File: rtl/cfgp_lock_fsm.sv
module cfgp_lock_fsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    output logic       is_open
);

    lock_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED:  if (key_wr && key_val == KEY_ENTER) state_d = ST_KEY_ONE;
            ST_KEY_ONE: if (key_wr) state_d = (key_val == KEY_ENTER) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:    if (key_wr && key_val == KEY_EXIT) state_d = ST_LOCKED;
            default:    state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        is_open = (state_q == ST_OPEN);
    end

    // R2: entering the open state needs an entry-key write in the prior cycle
    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |->
            $past(key_wr && key_val == KEY_ENTER));

    // R3: exit key always locks
    p_exit_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && key_wr && key_val == KEY_EXIT) |=> (state_q == ST_LOCKED));

endmodule

// File: rtl/cfgp_gpio_bank.sv
module cfgp_gpio_bank #(
    parameter int         PINS = 8,
    parameter logic [7:0] BASE = 8'hF0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    input  logic [7:0] pad_in,
    output logic       rd_hit,
    output logic [7:0] rd_val,
    output logic [7:0] pad_out,
    output logic [7:0] pad_oe
);

    localparam logic [7:0] MASK = 8'hFF >> (8 - PINS);

    logic [7:0] dir_q, lvl_q, style_q, sync1_q, sync2_q;
    logic       in_bank;
    logic [1:0] up_cnt;

    assign in_bank = sel && (idx[7:2] == BASE[7:2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            lvl_q   <= '0;
            style_q <= '0;
        end else if (wr_en && in_bank) begin
            unique case (idx[1:0])
                2'd0:    dir_q   <= wdata & MASK;
                2'd1:    lvl_q   <= wdata & MASK;
                2'd3:    style_q <= wdata & MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pad_in & MASK;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        rd_hit = in_bank;
        rd_val = '0;
        if (in_bank) begin
            unique case (idx[1:0])
                2'd0: rd_val = dir_q;
                2'd1: rd_val = lvl_q;
                2'd2: rd_val = sync2_q;
                2'd3: rd_val = style_q;
            endcase
        end
    end

    always_comb begin
        pad_out = dir_q & style_q & lvl_q;
        pad_oe  = dir_q & (style_q | ~lvl_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              up_cnt <= '0;
        else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
    end

    // R7: a direction write lands masked in the next cycle
    p_dir_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel && idx == BASE) |=> (dir_q == ($past(wdata) & MASK)));

    // R9: input register trails the pad by two edges
    p_input_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2) |-> (sync2_q == ($past(pad_in, 2) & MASK)));

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgp_pkg::*;
#(
    parameter int          NUM_BANKS = 3,
    parameter logic [31:0] BANK_PINS = 32'h0000_0658,
    parameter logic [15:0] DEV_ID    = 16'h0B17,
    parameter logic [7:0]  DEV_REV   = 8'h03,
    parameter logic [15:0] MFG_ID    = 16'h1934,
    localparam int         PAD_W     = NUM_BANKS * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic             io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic [PAD_W-1:0] pad_in,
    output logic [PAD_W-1:0] pad_out,
    output logic [PAD_W-1:0] pad_oe
);

    logic       is_open;
    logic       idx_wr, dat_wr, gpio_sel;
    logic [7:0] index_q, ldev_q;
    logic [7:0] glob_val, bank_val, data_val;
    logic       glob_hit;
    logic       hit_vec [NUM_BANKS];
    logic [7:0] val_vec [NUM_BANKS];

    assign idx_wr   = io_wr && !io_addr;
    assign dat_wr   = io_wr && io_addr;
    assign gpio_sel = (ldev_q == LDEV_GPIO);

    cfgp_lock_fsm u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .key_wr  (idx_wr),
        .key_val (io_wdata),
        .is_open (is_open)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            index_q <= '0;
            ldev_q  <= '0;
        end else begin
            if (idx_wr && is_open && io_wdata != KEY_EXIT) index_q <= io_wdata;
            if (dat_wr && is_open && index_q == IDX_LDEV)  ldev_q  <= io_wdata;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int         PINS_B = int'(BANK_PINS[b*4 +: 4]);
        localparam logic [7:0] BASE_B = BANK_TOP - 8'(b * BANK_STRIDE);
        cfgp_gpio_bank #(
            .PINS (PINS_B),
            .BASE (BASE_B)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (gpio_sel),
            .wr_en   (dat_wr && is_open),
            .idx     (index_q),
            .wdata   (io_wdata),
            .pad_in  (pad_in[b*8 +: 8]),
            .rd_hit  (hit_vec[b]),
            .rd_val  (val_vec[b]),
            .pad_out (pad_out[b*8 +: 8]),
            .pad_oe  (pad_oe[b*8 +: 8])
        );
    end

    always_comb begin
        glob_hit = 1'b1;
        glob_val = '0;
        case (index_q)
            IDX_LDEV:   glob_val = ldev_q;
            IDX_DID_HI: glob_val = DEV_ID[15:8];
            IDX_DID_LO: glob_val = DEV_ID[7:0];
            IDX_REV:    glob_val = DEV_REV;
            IDX_MID_HI: glob_val = MFG_ID[15:8];
            IDX_MID_LO: glob_val = MFG_ID[7:0];
            default:    glob_hit = 1'b0;
        endcase
    end

    always_comb begin
        bank_val = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (hit_vec[b]) bank_val = bank_val | val_vec[b];
        end
    end

    always_comb begin
        data_val = glob_hit ? glob_val : bank_val;
        if (!io_rd)        io_rdata = '0;
        else if (!is_open) io_rdata = LOCKED_READ;
        else if (io_addr)  io_rdata = data_val;
        else               io_rdata = index_q;
    end

    // R4: a data write while not open leaves the device selector untouched
    p_locked_write_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open && dat_wr) |=> $stable(ldev_q));

    // R5: selector changes only through an open data write at its index
    p_ldev_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dat_wr && is_open && index_q == IDX_LDEV)) |=> $stable(ldev_q));

endmodule

// File: tb/cfgport_ctrl_tb.sv
`timescale 1ns/1ps
module cfgport_ctrl_tb;

    localparam int PAD_W = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             io_wr = 1'b0, io_rd = 1'b0, io_addr = 1'b0;
    logic [7:0]       io_wdata = '0;
    logic [7:0]       io_rdata;
    logic [PAD_W-1:0] pad_in = '0;
    logic [PAD_W-1:0] pad_out, pad_oe;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    finished = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    cfgport_ctrl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .pad_in   (pad_in),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic rd, input logic a, input logic [7:0] d);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
    endtask

    task automatic idx_wr(input logic [7:0] v);  drive(1, 0, 0, v); endtask
    task automatic dat_wr(input logic [7:0] v);  drive(1, 0, 1, v); endtask

    task automatic rd_exp(input logic a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        drive(0, 1, a, 8'h00);
    endtask

    task automatic reg_rd(input logic [7:0] idx, input logic [7:0] e, input string tag);
        idx_wr(idx);
        rd_exp(1, e, tag);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] v);
        idx_wr(idx);
        dat_wr(v);
    endtask

    task automatic settle();
        drive(0, 0, 0, 8'h00);
        #1;
    endtask

    // monitor: scoreboard pops one expected item per read cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (io_rd) begin
                if (exp_q.size() == 0) begin
                    chk("scoreboard underflow", 32'h1, 32'h0);
                end else begin
                    chk(tag_q.pop_front(), 32'(io_rdata), 32'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #(4 * 100000);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        if (!finished) begin
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 reset pad_oe", 32'(pad_oe), 32'h0);
        chk("R11 reset pad_out", 32'(pad_out), 32'h0);
        rd_exp(1, 8'hFF, "R4 locked data read");
        rd_exp(0, 8'hFF, "R4 locked index read");
        // locked write attempt to the selector
        reg_wr(8'h07, 8'h06);
        // broken key sequence
        idx_wr(8'h87);
        idx_wr(8'h55);
        idx_wr(8'h87);
        rd_exp(1, 8'hFF, "R2 broken key stays locked");
        idx_wr(8'h87);
        rd_exp(0, 8'h00, "R2 open after two keys index read");
        reg_rd(8'h07, 8'h00, "R4 locked selector write ignored");
        reg_rd(8'h20, 8'h0B, "R6 device id high");
        reg_rd(8'h21, 8'h17, "R6 device id low");
        reg_rd(8'h22, 8'h03, "R6 revision");
        reg_rd(8'h23, 8'h19, "R6 maker id high");
        reg_rd(8'h24, 8'h34, "R6 maker id low");
        dat_wr(8'h55);
        rd_exp(1, 8'h34, "R6 id read-only");
        // bank access without the GPIO device selected
        reg_wr(8'hF0, 8'hFF);
        reg_rd(8'hF0, 8'h00, "R5 bank hidden before select");
        settle();
        chk("R5 hidden write no pad effect", 32'(pad_oe), 32'h0);
        reg_wr(8'h07, 8'h06);
        reg_rd(8'h07, 8'h06, "R5 selector readback");
        reg_rd(8'hF0, 8'h00, "R5 earlier bank write ignored");
        // bank 0: mixed drive styles
        reg_wr(8'hF3, 8'hF0);
        reg_wr(8'hF1, 8'h3C);
        reg_wr(8'hF0, 8'hFF);
        settle();
        chk("R8 bank0 oe mixed", 32'(pad_oe[7:0]), 32'hF3);
        chk("R8 bank0 out mixed", 32'(pad_out[7:0]), 32'h30);
        reg_rd(8'hF0, 8'hFF, "R7 bank0 direction");
        reg_rd(8'hF1, 8'h3C, "R7 bank0 level");
        reg_rd(8'hF3, 8'hF0, "R7 bank0 style");
        reg_wr(8'hF0, 8'h0F);
        settle();
        chk("R8 bank0 oe partial dir", 32'(pad_oe[7:0]), 32'h03);
        chk("R8 bank0 out partial dir", 32'(pad_out[7:0]), 32'h00);
        // bank 1: five pins
        reg_wr(8'hE0, 8'hFF);
        reg_rd(8'hE0, 8'h1F, "R10 narrow direction mask");
        settle();
        chk("R10 narrow oe", 32'(pad_oe[15:8]), 32'h1F);
        reg_wr(8'hE1, 8'hFF);
        reg_rd(8'hE1, 8'h1F, "R10 narrow level mask");
        settle();
        chk("R8 open-drain released oe", 32'(pad_oe[15:8]), 32'h00);
        chk("R8 open-drain out low", 32'(pad_out[15:8]), 32'h00);
        // bank 2: input synchronizer, six pins
        idx_wr(8'hD2);
        @(negedge clk);
        io_wr = 0; io_rd = 0; io_addr = 0; io_wdata = '0;
        pad_in[23:16] = 8'hEA;
        rd_exp(1, 8'h00, "R9 input not visible after one edge");
        rd_exp(1, 8'h2A, "R9 input visible after two edges");
        dat_wr(8'hFF);
        rd_exp(1, 8'h2A, "R7 input register write ignored");
        rd_exp(0, 8'hD2, "R1 index readback");
        settle();
        chk("R1 rdata zero without read", 32'(io_rdata), 32'h0);
        // lock again
        idx_wr(8'hAA);
        rd_exp(1, 8'hFF, "R3 locked after exit key");
        settle();
        chk("R3 pads hold after lock", 32'(pad_oe[7:0]), 32'h03);
        // reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R11 reset clears oe", 32'(pad_oe), 32'h0);
        chk("R11 reset clears out", 32'(pad_out), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_exp(1, 8'hFF, "R11 reset locks");
        settle();
        chk("scoreboard drained", 32'(exp_q.size()), 32'h0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule